// File: doc/BRIEF.md
# Message RAM parity error logger

This block sits beside a message buffer RAM that stores up to 64 message objects, each made of five 32-bit words with one stored parity bit per word. Every time the controller reads a word, the block sees the object number, the word index (1 to 5), the data and the stored parity bit. It recomputes even parity and compares the result with the stored bit. Errors found during one object's five-word read burst are gathered together. At the end of the burst they are turned into one update of a sticky error flag and a captured error code.

Software sees two read-only registers through a read strobe and a one-bit select. The status register holds the sticky flag. Reading it clears the flag. The code register reports where the last error was found: the object number and the highest failing word of that burst. The code has no reset and survives functional resets. Its contents are undefined until the first error has been captured.

Top module: `msg_ram_parity_logger`

## Requirements
- R1: A word counts as failing when its stored parity bit differs from the XOR of its 32 data bits (even parity). A burst whose stored parity bits all match leaves the flag and the code as they were.
- R2: A burst with at least one failing word sets the flag. The flag is visible on the clock edge that samples the burst's last word (`obs_last` high).
- R3: Once set, the flag stays set through later bursts that have no errors.
- R4: A status read is `rd_en` high with `rd_sel` = 0. It returns the flag in bit 0 and zeros in bits 31:1, and it clears the flag on that clock edge.
- R5: When a burst commits an error on the same edge as a status read, the flag is 1 after that edge.
- R6: A code read is `rd_en` high with `rd_sel` = 1. It returns the failing word number (1 to 5) in bits 10:8, the object number in bits 7:0 and zeros in bits 31:11.
- R7: When several words of one burst fail, the code shows the highest failing word number.
- R8: Observations with an object number outside 1 to 64 (00h, or 41h to FFh) or a word index outside 1 to 5 are ignored. They change neither the flag nor the code.
- R9: Reset clears the flag. The captured code keeps its value across reset and across reads of either register.
- R10: A later failing burst replaces the code with its own object and word.
- R11: A code read leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| obs_valid | input | 1 | A RAM word read is being observed this cycle |
| obs_obj | input | 8 | Message object number of the read |
| obs_word | input | 3 | Word index within the object, 1 to 5 |
| obs_data | input | 32 | Data word read from the RAM |
| obs_par | input | 1 | Stored parity bit of that word |
| obs_last | input | 1 | Marks the last word of the object's read burst |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects status, 1 selects error code |
| rd_data | output | 32 | Combinational read data for the selected register |

## Verification
The bench builds the block with its defaults: 64 objects, five words per object and 32-bit data. With these values the top valid object (40h) and the first invalid ones (00h, 41h) are one step apart, so both sides of the range check are tested. The five-word burst also allows failure masks in which the highest failing word is not the last word read, and a mask in which every word fails. A status read placed on the same cycle as a burst's last word exercises the collision between setting and clearing the flag.

// File: rtl/mrpl_pkg.sv
package mrpl_pkg;
  localparam int OBJ_W  = 8;
  localparam int WIDX_W = 3;

  typedef struct packed {
    logic [WIDX_W-1:0] word;
    logic [OBJ_W-1:0]  obj;
  } err_code_t;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CODE   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mrpl_rst_sync.sv
module mrpl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mrpl_parity_chk.sv
module mrpl_parity_chk #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              mismatch
);
  logic calc_par;

  always_comb begin
    calc_par = ^data;
    mismatch = calc_par ^ par;
  end
endmodule

// File: rtl/mrpl_burst_acc.sv
module mrpl_burst_acc
  import mrpl_pkg::*;
#(
  parameter int NUM_OBJ = 64,
  parameter int WORDS   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [OBJ_W-1:0]  obs_obj,
  input  logic [WIDX_W-1:0] obs_word,
  input  logic              obs_last,
  input  logic              word_bad,
  output logic              commit,
  output err_code_t         commit_code
);
  localparam logic [OBJ_W-1:0]  MaxObj  = OBJ_W'(NUM_OBJ);
  localparam logic [WIDX_W-1:0] MaxWord = WIDX_W'(WORDS);

  logic              seen_q, seen_d;
  err_code_t         acc_q, acc_d;
  logic              loc_ok, cur_fail;
  err_code_t         merged;

  always_comb begin
    loc_ok   = (obs_obj != '0) && (obs_obj <= MaxObj) &&
               (obs_word != '0) && (obs_word <= MaxWord);
    cur_fail = obs_valid && loc_ok && word_bad;

    merged = acc_q;
    if (cur_fail) begin
      merged.obj = obs_obj;
      if (!seen_q || (obs_word > acc_q.word)) merged.word = obs_word;
    end

    commit      = obs_valid && obs_last && (seen_q || cur_fail);
    commit_code = merged;

    seen_d = seen_q;
    acc_d  = acc_q;
    if (obs_valid) begin
      if (obs_last) begin
        seen_d = 1'b0;
        acc_d  = '0;
      end else begin
        seen_d = seen_q || cur_fail;
        acc_d  = merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      acc_q  <= '0;
    end else if (obs_valid) begin
      seen_q <= seen_d;
      acc_q  <= acc_d;
    end
  end

  p_word_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_code.word != '0) && (commit_code.word <= MaxWord));
  p_obj_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_code.obj != '0) && (commit_code.obj <= MaxObj));
endmodule

// File: rtl/mrpl_err_regs.sv
module mrpl_err_regs
  import mrpl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit,
  input  err_code_t commit_code,
  input  logic      status_rd,
  output logic      flag_q,
  output err_code_t code_q
);
  logic      flag_d;
  err_code_t code_d;

  always_comb begin
    flag_d = flag_q;
    if (commit)         flag_d = 1'b1;
    else if (status_rd) flag_d = 1'b0;
    code_d = commit_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk) begin
    if (commit) code_q <= code_d;
  end

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> flag_q);
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !status_rd) |=> flag_q);
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !commit) |=> !flag_q);
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(code_q));
endmodule

// File: rtl/msg_ram_parity_logger.sv
module msg_ram_parity_logger
  import mrpl_pkg::*;
#(
  parameter int NUM_OBJ = 64,
  parameter int WORDS   = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [OBJ_W-1:0]  obs_obj,
  input  logic [WIDX_W-1:0] obs_word,
  input  logic [DATA_W-1:0] obs_data,
  input  logic              obs_par,
  input  logic              obs_last,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [31:0]       rd_data
);
  localparam int CodeW = OBJ_W + WIDX_W;

  logic      rst_s_n;
  logic      word_bad;
  logic      commit;
  err_code_t commit_code;
  logic      status_rd;
  logic      flag_q;
  err_code_t code_q;

  mrpl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  mrpl_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data(obs_data), .par(obs_par), .mismatch(word_bad)
  );

  mrpl_burst_acc #(.NUM_OBJ(NUM_OBJ), .WORDS(WORDS)) u_acc (
    .clk(clk), .rst_n(rst_s_n), .obs_valid(obs_valid), .obs_obj(obs_obj),
    .obs_word(obs_word), .obs_last(obs_last), .word_bad(word_bad),
    .commit(commit), .commit_code(commit_code)
  );

  assign status_rd = rd_en && (reg_sel_e'(rd_sel) == SEL_STATUS);

  mrpl_err_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .commit(commit), .commit_code(commit_code),
    .status_rd(status_rd), .flag_q(flag_q), .code_q(code_q)
  );

  always_comb begin
    if (reg_sel_e'(rd_sel) == SEL_STATUS) rd_data = {31'd0, flag_q};
    else                                  rd_data = {{(32-CodeW){1'b0}}, code_q};
  end
endmodule

// File: tb/msg_ram_parity_logger_tb.sv
module msg_ram_parity_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        obs_valid, obs_par, obs_last, rd_en, rd_sel;
  logic [7:0]  obs_obj;
  logic [2:0]  obs_word;
  logic [31:0] obs_data;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  msg_ram_parity_logger u_dut (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_obj(obs_obj),
    .obs_word(obs_word), .obs_data(obs_data), .obs_par(obs_par),
    .obs_last(obs_last), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    #1;
    if (rd_en && !done) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected read: actual %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic do_read(input logic sel, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // burst of five words; mask bit w flips the stored parity of word w
  // if rd_last is set, a status read with expectation e is issued on the last word
  task automatic burst(input logic [7:0] obj, input logic [5:1] mask, input int salt,
                       input bit rd_last, input logic [31:0] e, input string t);
    for (int w = 1; w <= 5; w++) begin
      logic [31:0] d;
      @(negedge clk);
      d = {obj, 8'(w), 16'(salt * 7919 + w * 613)};
      obs_valid = 1'b1; obs_obj = obj; obs_word = 3'(w);
      obs_data = d; obs_par = (^d) ^ mask[w]; obs_last = (w == 5);
      if (w == 5 && rd_last) begin
        rd_en = 1'b1; rd_sel = 1'b0;
        exp_q.push_back(e); tag_q.push_back(t);
      end
    end
    @(negedge clk);
    obs_valid = 1'b0; obs_last = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; obs_valid = 0; obs_par = 0; obs_last = 0; rd_en = 0; rd_sel = 0;
    obs_obj = '0; obs_word = '0; obs_data = '0;
    do_reset();

    do_read(1'b0, 32'h0, "R9 flag clear after reset");
    burst(8'd3, 5'b00000, 1, 0, 0, "");
    do_read(1'b0, 32'h0, "R1 clean burst leaves flag low");

    burst(8'd7, 5'b00010, 2, 0, 0, "");
    do_read(1'b1, 32'h0000_0207, "R6 code layout obj 7 word 2");
    do_read(1'b0, 32'h1, "R2 flag set / R11 code read kept flag");
    do_read(1'b0, 32'h0, "R4 status read cleared flag");

    burst(8'h40, 5'b01010, 3, 0, 0, "");
    burst(8'd10, 5'b00000, 4, 0, 0, "");
    do_read(1'b1, 32'h0000_0440, "R7 highest failing word 4 of obj 64");
    do_read(1'b0, 32'h1, "R3 flag sticky over clean burst");

    burst(8'h41, 5'b11111, 5, 0, 0, "");
    burst(8'h00, 5'b00001, 6, 0, 0, "");
    do_read(1'b0, 32'h0, "R8 invalid objects do not set flag");
    do_read(1'b1, 32'h0000_0440, "R8 invalid objects do not change code");

    burst(8'd5, 5'b10000, 7, 1, 32'h0, "R5 status during commit returns old flag");
    do_read(1'b0, 32'h1, "R5 new error wins over same-cycle read");
    do_read(1'b1, 32'h0000_0505, "R10 later error replaces code");

    burst(8'd33, 5'b11111, 8, 0, 0, "");
    do_read(1'b1, 32'h0000_0521, "R7 all words fail reports word 5");

    do_reset();
    do_read(1'b0, 32'h0, "R9 reset clears flag");
    do_read(1'b1, 32'h0000_0521, "R9 code retained across reset");
    do_read(1'b1, 32'h0000_0521, "R9 code retained across reads");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule